// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Square-Wave Output

This block sits between the timekeeping oscillator and the calendar counter of a real-time clock. It counts phase strobes from the oscillator (one strobe per half oscillator period, so 65,536 strobes per nominal second at the default width). From this count it makes a single-cycle one-second tick for the calendar, and it drives a square-wave pin at one of four selectable rates. When the square wave is disabled, the pin holds a programmable static level instead.

The block also holds the control byte for the pin and a sticky oscillator-stop flag, which the host reads and writes through a simple byte port. A strobe from the seconds register restarts the divider. After that strobe, the next one-second boundary is a full second away, and the one-hertz wave rises at the half-second point. The divider counts only while the oscillator reports running and the clock-halt bit is clear.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset, the control byte reads 0xB3 and `sec_tick` is 0.
- R2: The control byte has the following layout. Bit 7 is the static level, bit 5 is the stop flag, bit 4 is the wave enable, and bits 1:0 are the rate code. Bits 6, 3 and 2 always read 0. A write takes effect on the next clock edge, and `ctl_rdata` shows it from then on.
- R3: With the wave enable at 1, the rate code selects the divider stage on `sqw_out`, each with a 50% duty cycle. Code 00 is bit CNT_W-1 (1 Hz). Code 01 is bit 3 (4.096 kHz). Code 10 is bit 2 (8.192 kHz). Code 11 is bit 0 (32.768 kHz). `sqw_out` follows the divider one clock later.
- R4: With the wave enable at 0, `sqw_out` equals the static level bit. It updates one clock after the control byte changes.
- R5: A `sec_load` pulse clears the divider. With strobes every cycle afterwards, the 1 Hz wave first goes high 2^(CNT_W-1) strobes later, and `sec_load` suppresses any tick in its own cycle.
- R6: `sec_tick` is a single-cycle pulse. It is raised once every 2^CNT_W counted strobes, the first one 2^CNT_W strobes after a `sec_load`.
- R7: While `osc_running` is 0 or `clock_halt` is 1, the divider holds its value. During that time no `sec_tick` is produced and the wave does not advance.
- R8: The stop flag (bit 5) is set in the cycle that the condition (`osc_running` and not `clock_halt`) goes from true to false. Setting has priority over a clearing write in the same cycle.
- R9: The stop flag stays 1 until a write with bit 5 at 0 clears it. A write with bit 5 at 1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_strobe | input | 1 | One pulse per oscillator half period |
| osc_running | input | 1 | Oscillator reports it is running |
| clock_halt | input | 1 | Clock-halt bit from the seconds register |
| sec_load | input | 1 | Pulse when the seconds register is written |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| sec_tick | output | 1 | One-cycle pulse per second to the calendar |
| sqw_out | output | 1 | Square wave or static level |

## Verification
This section gives, for a stimulus applied before clock edge N, the edge at which each result appears.

- **Control byte and stop flag:** a control write, or a stop event, shows on `ctl_rdata` after edge N.
- **Wave output:** a control change reaches `sqw_out` after edge N+1.
- **Divider after `sec_load`:** when `sec_load` is sampled at edge N, the divider holds k after edge N+k. The wave level for count k appears after edge N+k+1. The tick follows edge N+2^CNT_W.

The driver tasks turn these latencies into absolute cycle numbers when they queue each expectation. The monitor compares every queued item in exactly that cycle, and it flags an item it reaches late as a failure. For the hold-off cases, the bench checks the wave level and a running tick count at points where a free-running divider would already have moved them.

// File: rtl/rtc_prsc_pkg.sv
// Shared types and tap positions for the real-time clock prescaler.
// Assumes the divider input is a strobe at twice the oscillator rate,
// so divider bit k toggles at 65536 / 2^(k+1) Hz for the default width.
package rtc_prsc_pkg;

    typedef enum logic [1:0] {
        RATE_1HZ  = 2'b00,
        RATE_4K   = 2'b01,
        RATE_8K   = 2'b10,
        RATE_32K  = 2'b11
    } rate_e;

    typedef struct packed {
        logic  lvl;      // static level when the wave is off
        logic  osf;      // sticky oscillator-stop flag
        logic  wave_en;  // square-wave enable
        rate_e rate;     // rate code
    } ctl_t;

    // Bit positions in the host-visible control byte
    localparam int LVL_BIT  = 7;
    localparam int OSF_BIT  = 5;
    localparam int WEN_BIT  = 4;
    localparam int RATE_LSB = 0;

    // Divider bit feeding each rate code
    function automatic int tap_index(input int code, input int cnt_w);
        case (code)
            0:       return cnt_w - 1;
            1:       return 3;
            2:       return 2;
            default: return 0;
        endcase
    endfunction

    // Pack the control fields into the byte seen by the host
    function automatic logic [7:0] ctl_to_byte(input ctl_t c);
        logic [7:0] b;
        b = 8'h00;
        b[LVL_BIT]                = c.lvl;
        b[OSF_BIT]                = c.osf;
        b[WEN_BIT]                = c.wave_en;
        b[RATE_LSB+1:RATE_LSB]    = c.rate;
        return b;
    endfunction

endpackage

// File: rtl/rtc_prsc_divider.sv
// Binary divider chain counting oscillator strobes.
// Assumes strobes are single-cycle. Clear has priority over counting.
// Produces every stage as a tap and a one-cycle tick on wrap to zero.
module rtc_prsc_divider #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             run,
    input  logic             clear,
    output logic [CNT_W-1:0] taps,
    output logic             tick
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             adv;

    // A strobe counts only while the oscillator is running and not halted
    assign adv = strobe && run;

    // Counter: cleared by a seconds write, advanced by qualified strobes
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick register: one pulse when the counter wraps from all-ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            tick <= adv && !clear && (cnt_q == CNT_MAX);
        end
    end

    assign taps = cnt_q;

endmodule

// File: rtl/rtc_prsc_ctlreg.sv
// Control byte for the square-wave pin plus the sticky stop flag.
// Assumes run is the qualified oscillator status. A falling run sets the
// flag, and the flag may only be cleared by software.
module rtc_prsc_ctlreg
    import rtc_prsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       wr,
    input  logic [7:0] wdata,
    output ctl_t       ctl,
    output logic [7:0] rdata
);
    logic run_q;
    logic stop_evt;

    // Previous-cycle run status, tracked through reset as well
    always_ff @(posedge clk) begin
        run_q <= run;
    end

    assign stop_evt = run_q && !run;

    // Writable fields: level, enable and rate load on a host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl.lvl     <= 1'b1;
            ctl.wave_en <= 1'b1;
            ctl.rate    <= RATE_32K;
        end else if (wr) begin
            ctl.lvl     <= wdata[LVL_BIT];
            ctl.wave_en <= wdata[WEN_BIT];
            ctl.rate    <= rate_e'(wdata[RATE_LSB+1:RATE_LSB]);
        end
    end

    // Stop flag: set on a stop event, cleared only by writing zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl.osf <= 1'b1;
        end else if (stop_evt) begin
            ctl.osf <= 1'b1;
        end else if (wr && !wdata[OSF_BIT]) begin
            ctl.osf <= 1'b0;
        end
    end

    assign rdata = ctl_to_byte(ctl);

endmodule

// File: rtl/rtc_prsc_wave.sv
// Output selector for the square-wave pin.
// Assumes the taps come straight from the divider. The pin is registered
// so that it cannot glitch while the rate code or the divider changes.
module rtc_prsc_wave
    import rtc_prsc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] taps,
    input  ctl_t             ctl,
    output logic             sqw
);
    localparam int N_RATES = 4;

    logic [N_RATES-1:0] cand;
    logic               nxt;

    // One candidate wave per rate code, picked from the matching stage
    for (genvar i = 0; i < N_RATES; i++) begin : g_tap
        localparam int POS = tap_index(i, CNT_W);
        assign cand[i] = taps[POS];
    end

    // Choose between the selected wave and the static level
    always_comb begin
        nxt = ctl.wave_en ? cand[ctl.rate] : ctl.lvl;
    end

    // Pin register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sqw <= 1'b0;
        end else begin
            sqw <= nxt;
        end
    end

endmodule

// File: rtl/rtc_prescaler.sv
// Real-time clock prescaler: divides oscillator strobes into a one-second
// tick and a selectable square wave, and holds the pin control byte.
// Assumes osc_strobe pulses once per oscillator half period (CNT_W >= 5).
module rtc_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_strobe,
    input  logic       osc_running,
    input  logic       clock_halt,
    input  logic       sec_load,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    output logic       sec_tick,
    output logic       sqw_out
);
    import rtc_prsc_pkg::*;

    logic             run;
    logic [CNT_W-1:0] taps;
    ctl_t             ctl;

    // Oscillator counts only when running and not halted
    assign run = osc_running && !clock_halt;

    rtc_prsc_divider #(.CNT_W(CNT_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (osc_strobe),
        .run    (run),
        .clear  (sec_load),
        .taps   (taps),
        .tick   (sec_tick)
    );

    rtc_prsc_ctlreg u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .wr     (ctl_wr),
        .wdata  (ctl_wdata),
        .ctl    (ctl),
        .rdata  (ctl_rdata)
    );

    rtc_prsc_wave #(.CNT_W(CNT_W)) u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .taps   (taps),
        .ctl    (ctl),
        .sqw    (sqw_out)
    );

endmodule

// File: rtl/rtc_prescaler_chk.sv
// Port-level properties of the prescaler, attached by bind.
// Assumes reset is held for at least two clock edges.
module rtc_prescaler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_strobe,
    input logic       osc_running,
    input logic       clock_halt,
    input logic       sec_load,
    input logic       ctl_wr,
    input logic [7:0] ctl_rdata,
    input logic       sec_tick,
    input logic       sqw_out
);
    p_static_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctl_rdata[4]) |-> (sqw_out == $past(ctl_rdata[7])));

    p_load_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_load |=> !sec_tick);

    p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    p_tick_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> $past(osc_running && !clock_halt && osc_strobe));

    p_stop_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_running && !clock_halt) |=> ctl_rdata[5]);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[5] && !ctl_wr) |=> ctl_rdata[5]);

endmodule

bind rtc_prescaler rtc_prescaler_chk u_chk (.*);

// File: tb/sim_rtc_prescaler.sv
// Scoreboard bench: driver tasks queue expectations, monitor compares them.
module sim_rtc_prescaler;
    localparam int W    = 10;
    localparam int HALF = 1 << (W - 1);
    localparam int FULL = 1 << W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_strobe = 1'b0;
    logic       osc_running = 1'b1;
    logic       clock_halt = 1'b0;
    logic       sec_load = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       sec_tick;
    logic       sqw_out;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int tick_seen = 0;
    bit done = 1'b0;

    // Expectation queues; kind 0 = sqw_out, 1 = sec_tick, 2 = ctl_rdata, 3 = tick count
    int    due_q[$];
    int    kind_q[$];
    int    val_q[$];
    string tag_q[$];

    rtc_prescaler #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_strobe(osc_strobe),
        .osc_running(osc_running), .clock_halt(clock_halt),
        .sec_load(sec_load), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sec_tick(sec_tick), .sqw_out(sqw_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: count ticks, then compare every item due in this cycle
    always @(negedge clk) begin
        int act;
        if (sec_tick === 1'b1) tick_seen = tick_seen + 1;
        while (due_q.size() > 0 && due_q[0] <= cyc) begin
            case (kind_q[0])
                0:       act = int'(sqw_out);
                1:       act = int'(sec_tick);
                2:       act = int'(ctl_rdata);
                default: act = tick_seen;
            endcase
            checks = checks + 1;
            if (due_q[0] < cyc || act != val_q[0]) begin
                errors = errors + 1;
                $display("FAIL %s: kind %0d at cycle %0d got %0h expected %0h",
                         tag_q[0], kind_q[0], cyc, act, val_q[0]);
            end
            void'(due_q.pop_front());
            void'(kind_q.pop_front());
            void'(val_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic expect_in(input int dly, input int kind, input int val, input string tag);
        due_q.push_back(cyc + dly);
        kind_q.push_back(kind);
        val_q.push_back(val);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Host write; the read-back is due one cycle later
    task automatic wr_ctl(input logic [7:0] d, input logic [7:0] exp_rd, input string tag);
        ctl_wdata = d;
        ctl_wr    = 1'b1;
        expect_in(1, 2, int'(exp_rd), tag);
        @(negedge clk);
        ctl_wr    = 1'b0;
    endtask

    task automatic pulse_load();
        sec_load = 1'b1;
        @(negedge clk);
        sec_load = 1'b0;
    endtask

    // Select a fast rate, restart the divider, check two edges of stage b
    task automatic rate_check(input logic [7:0] ctlv, input int b, input string tag);
        wr_ctl(ctlv, ctlv, tag);
        idle(3);
        expect_in(2 + (1 << b) - 1, 0, 0, tag);
        expect_in(2 + (1 << b),     0, 1, tag);
        expect_in(2 + (2 << b) - 1, 0, 1, tag);
        expect_in(2 + (2 << b),     0, 0, tag);
        pulse_load();
        idle((2 << b) + 4);
    endtask

    initial begin
        int snap;
        idle(5);
        rst_n = 1'b1;
        // R1: reset value of the control byte and idle tick
        expect_in(1, 2, 8'hB3, "R1");
        expect_in(1, 1, 0, "R1");
        osc_strobe = 1'b1;
        idle(2);

        // R2 / R9: writing 1 to the flag keeps it, writing 0 clears it
        wr_ctl(8'hFF, 8'hB3, "R2");
        wr_ctl(8'h00, 8'h00, "R9");
        wr_ctl(8'h20, 8'h00, "R9");
        wr_ctl(8'h13, 8'h13, "R2");

        // R4: static level when the wave is off
        wr_ctl(8'h80, 8'h80, "R4");
        expect_in(1, 0, 1, "R4");
        expect_in(2, 0, 1, "R4");
        idle(4);
        wr_ctl(8'h03, 8'h03, "R4");
        expect_in(1, 0, 0, "R4");
        idle(3);

        // R3: fast rates from their own stages
        rate_check(8'h13, 0, "R3");
        rate_check(8'h12, 2, "R3");
        rate_check(8'h11, 3, "R3");

        // R3 / R5 / R6: 1 Hz wave and tick after a seconds write
        wr_ctl(8'h10, 8'h10, "R3");
        idle(3);
        snap = tick_seen;
        expect_in(1 + HALF,     0, 0, "R5");
        expect_in(2 + HALF,     0, 1, "R5");
        expect_in(FULL,         1, 0, "R6");
        expect_in(1 + FULL,     0, 1, "R3");
        expect_in(1 + FULL,     1, 1, "R6");
        expect_in(2 + FULL,     0, 0, "R3");
        expect_in(2 + FULL,     1, 0, "R6");
        expect_in(2 + FULL,     3, snap + 1, "R6");
        pulse_load();
        idle(FULL + 4);

        // R7 / R8: halt freezes the divider and sets the stop flag
        pulse_load();
        idle(100);
        clock_halt = 1'b1;
        snap = tick_seen;
        expect_in(1,        2, 8'h30, "R8");
        expect_in(HALF + 100, 0, 0, "R7");
        expect_in(FULL + 200, 3, snap, "R7");
        idle(FULL + 204);
        clock_halt = 1'b0;
        idle(2);
        wr_ctl(8'h10, 8'h10, "R9");
        idle(50);

        // R7 / R8: oscillator stop behaves the same way
        osc_running = 1'b0;
        snap = tick_seen;
        expect_in(1,        2, 8'h30, "R8");
        expect_in(HALF + 100, 0, 0, "R7");
        expect_in(FULL + 200, 3, snap, "R7");
        idle(FULL + 204);
        osc_running = 1'b1;
        idle(4);

        if (due_q.size() != 0) begin
            errors = errors + 1;
            $display("FAIL R1: %0d expectations left got %0d expected 0", due_q.size(), due_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung got %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule